// File: doc/BRIEF.md
# Mode-0 Interrupt Controller with CALL Injection

This block sits beside an 8-bit CPU of the early microprocessor style. That CPU handles a mode-0 interrupt by running whatever instruction appears on the data bus. The block collects eight interrupt request lines and gives each one a fixed priority. When a request may be served, the block pulls the shared interrupt line low. The CPU then answers with an acknowledge cycle, in which M1 and IORQ are both low. In that cycle the block drives the opcode of a three-byte subroutine call. The CPU fetches the other two bytes of the call with two ordinary memory reads. The block answers those reads with the low byte and then the high byte of the handler address for the winning line. The program counter does not advance over these bytes.

For the whole injection the block raises a memory-inhibit output so that system memory stays off the data bus. The inhibit holds from the acknowledge cycle until the CPU makes its next opcode fetch (M1 and MREQ low together), which is the first instruction of the handler. The host writes the handler addresses with I/O writes, one byte per port. An acknowledged line becomes in-service and masks every line of equal or lower priority. It leaves service when the host writes a clear port, or when the block sees the return-from-interrupt pair of opcodes on two opcode fetches in a row.

All bus control inputs are active low. They are sampled on the rising clock edge, so every output reacts one clock after the input that causes it.

Top module: `irq_call_inject`

## Requirements
- R1: After reset, int_n is high, mem_inhibit is low, dout_oe is low, and no line is pending or in service.
- R2: A rising edge on irq_req[i] makes line i pending. int_n goes low two clocks later if line i is not masked by service.
- R3: Among the pending lines that are allowed, the lowest index wins (index 0 has the highest priority).
- R4: When M1 and IORQ are sampled low together while a line may be served, the block drives 0xCD on dout with dout_oe high for that acknowledge cycle.
- R5: The first memory read (MREQ and RD low, M1 high) after the acknowledge returns bits 7:0 of the winner's handler address. The second read returns bits 15:8. dout_oe is high only while such a read is sampled.
- R6: mem_inhibit goes high one clock after the acknowledge is sampled. It stays high until an opcode fetch (M1 and MREQ low) is sampled, and drops one clock later.
- R7: The winning index is captured when the acknowledge starts. A higher-priority request that arrives during the injection does not change the bytes being fed.
- R8: An acknowledged line stops being pending and becomes in-service. An in-service line keeps int_n high for itself and for every line of lower priority. Lines of higher priority can still raise int_n.
- R9: An I/O write to port BASE_PORT+16 clears every in-service bit whose data bit is 1.
- R10: Opcode fetches of 0xED and then 0x4D, with no other fetch between them, clear the in-service bit of highest priority. Any other fetch between the two bytes cancels the match.
- R11: An I/O write to port BASE_PORT+2i loads bits 7:0 of the handler address for line i. A write to BASE_PORT+2i+1 loads bits 15:8.
- R12: Once both address bytes have been read, later memory reads inside the same injection get no drive (dout_oe stays low).
- R13: An acknowledge cycle with no line eligible gets no drive and does not raise mem_inhibit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 8 | Interrupt request lines; a rising edge requests service |
| m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| addr | input | 8 | Low byte of the CPU address bus (I/O port number) |
| din | input | 8 | Data bus as seen by the block |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| dout | output | 8 | Byte the block drives; zero when dout_oe is low |
| dout_oe | output | 1 | Enable for the block's data bus driver |
| mem_inhibit | output | 1 | High while memory must stay off the data bus |

## Verification
A bad latched index or a bad byte phase shows up within one clock of the next memory read after an acknowledge, as a wrong address byte or a missing drive enable. Bad in-service or pending state shows up as int_n at the wrong level two clocks after a request edge or a clear. A feeding flag that is stuck on or off shows at mem_inhibit from the clock after the acknowledge up to the clock after the next opcode fetch. The bench keeps its own model of pending, in-service and vector state. It compares int_n, dout, dout_oe and mem_inhibit after every bus cycle.

// File: rtl/irqci_pkg.sv
package irqci_pkg;

    localparam logic [7:0] OP_CALL  = 8'hCD;
    localparam logic [7:0] OP_PRE   = 8'hED;
    localparam logic [7:0] OP_RETI2 = 8'h4D;

    // which byte of the injected call comes next
    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // bus strobes, converted to active high
    typedef struct packed {
        logic m1;
        logic iorq;
        logic mreq;
        logic rd;
        logic wr;
    } bus_t;

    function automatic bus_t decode_bus(input logic m1_n, input logic iorq_n,
                                        input logic mreq_n, input logic rd_n,
                                        input logic wr_n);
        bus_t b;
        b.m1   = ~m1_n;
        b.iorq = ~iorq_n;
        b.mreq = ~mreq_n;
        b.rd   = ~rd_n;
        b.wr   = ~wr_n;
        return b;
    endfunction

endpackage

// File: rtl/irqci_vec_regs.sv
module irqci_vec_regs #(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 16,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W:0]   wr_off,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);
    logic [VEC_W-1:0] vec_q [N_IRQ];

    for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[g] <= '0;
            end else if (wr_en && wr_off[IDX_W:1] == IDX_W'(g)) begin
                if (wr_off[0]) vec_q[g][15:8] <= wr_data;
                else           vec_q[g][7:0]  <= wr_data;
            end
        end
    end

    assign rd_vec = vec_q[rd_idx];

endmodule

// File: rtl/irqci_prio.sv
module irqci_prio #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] req_s,
    input  logic             take,
    input  logic             clr_wr,
    input  logic [N_IRQ-1:0] clr_mask,
    input  logic             reti_hit,
    output logic             int_req,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);
    logic [N_IRQ-1:0] req_q, rise, pending, insvc, allow, cand, grant_oh, svc_top;

    assign rise = req_s & ~req_q;

    // a line may be served only if no line of equal or higher priority is in service
    for (genvar g = 0; g < N_IRQ; g++) begin : g_allow
        assign allow[g] = ~|insvc[g:0];
    end

    assign cand     = pending & allow;
    assign grant_oh = cand & (~cand + 1'b1);
    assign svc_top  = insvc & (~insvc + 1'b1);
    assign win_valid = |cand;
    assign int_req   = |cand;

    always_comb begin
        win_idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (grant_oh[i]) win_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            pending <= '0;
            insvc   <= '0;
        end else begin
            req_q   <= req_s;
            pending <= (pending & ~(take ? grant_oh : '0)) | rise;
            insvc   <= (insvc | (take ? grant_oh : '0))
                       & ~(clr_wr ? clr_mask : '0)
                       & ~(reti_hit ? svc_top : '0);
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh));

    // R2
    int_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (pending != '0));

    // R8
    taken_goes_insvc_chk: assert property (@(posedge clk) disable iff (rst)
        (take && win_valid) |=> (insvc != '0));

endmodule

// File: rtl/irqci_feeder.sv
module irqci_feeder #(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 16,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_now,
    input  logic             ack_start,
    input  logic             mread_now,
    input  logic             mread_end,
    input  logic             fetch_now,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [VEC_W-1:0] vec,
    output logic             take,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       dout,
    output logic             dout_oe,
    output logic             mem_inhibit
);
    import irqci_pkg::*;

    logic   feeding;
    phase_e phase;
    logic   addr_phase;

    assign take       = ack_start & ~feeding & win_valid;
    assign addr_phase = (phase == PH_LO) || (phase == PH_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            feeding <= 1'b0;
            phase   <= PH_OP;
            idx     <= '0;
        end else if (take) begin
            feeding <= 1'b1;
            phase   <= PH_LO;
            idx     <= win_idx;
        end else begin
            if (fetch_now) feeding <= 1'b0;
            if (feeding && mread_end && phase != PH_DONE)
                phase <= phase_e'(phase + 2'd1);
        end
    end

    assign dout_oe = (ack_now & (feeding | take))
                   | (mread_now & feeding & addr_phase);

    always_comb begin
        dout = 8'h00;
        if (dout_oe) begin
            if (ack_now)              dout = OP_CALL;
            else if (phase == PH_LO)  dout = vec[7:0];
            else                      dout = vec[15:8];
        end
    end

    assign mem_inhibit = feeding;

    // R6
    fetch_ends_feed_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(feeding) |-> $past(fetch_now));

    // R5
    oe_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (ack_now || mread_now));

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (feeding && $past(feeding)) |-> $stable(idx));

    // R12
    no_fourth_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && !ack_now) |-> !dout_oe);

endmodule

// File: rtl/irq_call_inject.sv
module irq_call_inject #(
    parameter int         N_IRQ     = 8,
    parameter logic [7:0] BASE_PORT = 8'h40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             mreq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [7:0]       addr,
    input  logic [7:0]       din,
    output logic             int_n,
    output logic [7:0]       dout,
    output logic             dout_oe,
    output logic             mem_inhibit
);
    import irqci_pkg::*;

    localparam int         IDX_W    = $clog2(N_IRQ);
    localparam int         VEC_W    = 16;
    localparam logic [7:0] VEC_SPAN = 8'(2 * N_IRQ);

    bus_t             bs, bs_q;
    logic [7:0]       s_addr, s_din, off;
    logic [N_IRQ-1:0] s_req;
    logic             pre_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            bs     <= '0;
            bs_q   <= '0;
            s_addr <= '0;
            s_din  <= '0;
            s_req  <= '0;
        end else begin
            bs     <= decode_bus(m1_n, iorq_n, mreq_n, rd_n, wr_n);
            bs_q   <= bs;
            s_addr <= addr;
            s_din  <= din;
            s_req  <= irq_req;
        end
    end

    logic ack_now, ack_start, mread_now, mread_end, fetch_now, fetch_start;
    logic io_wr_start, vec_wr, clr_wr, reti_hit;

    assign ack_now     = bs.m1 & bs.iorq;
    assign ack_start   = ack_now & ~(bs_q.m1 & bs_q.iorq);
    assign mread_now   = bs.mreq & bs.rd & ~bs.m1;
    assign mread_end   = ~mread_now & bs_q.mreq & bs_q.rd & ~bs_q.m1;
    assign fetch_now   = bs.m1 & bs.mreq;
    assign fetch_start = fetch_now & bs.rd & ~(bs_q.m1 & bs_q.mreq & bs_q.rd);
    assign io_wr_start = bs.iorq & bs.wr & ~bs.m1 & ~(bs_q.iorq & bs_q.wr & ~bs_q.m1);

    assign off      = s_addr - BASE_PORT;
    assign vec_wr   = io_wr_start && (off < VEC_SPAN);
    assign clr_wr   = io_wr_start && (off == VEC_SPAN);
    assign reti_hit = fetch_start && pre_seen && (s_din == OP_RETI2);

    always_ff @(posedge clk) begin
        if (rst)              pre_seen <= 1'b0;
        else if (fetch_start) pre_seen <= (s_din == OP_PRE);
    end

    logic             int_req, win_valid, take;
    logic [IDX_W-1:0] win_idx, cur_idx;
    logic [VEC_W-1:0] cur_vec;

    irqci_vec_regs #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (vec_wr),
        .wr_off  (off[IDX_W:0]),
        .wr_data (s_din),
        .rd_idx  (cur_idx),
        .rd_vec  (cur_vec)
    );

    irqci_prio #(.N_IRQ(N_IRQ)) u_prio (
        .clk       (clk),
        .rst       (rst),
        .req_s     (s_req),
        .take      (take),
        .clr_wr    (clr_wr),
        .clr_mask  (s_din[N_IRQ-1:0]),
        .reti_hit  (reti_hit),
        .int_req   (int_req),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    irqci_feeder #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_feed (
        .clk         (clk),
        .rst         (rst),
        .ack_now     (ack_now),
        .ack_start   (ack_start),
        .mread_now   (mread_now),
        .mread_end   (mread_end),
        .fetch_now   (fetch_now),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .vec         (cur_vec),
        .take        (take),
        .idx         (cur_idx),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .mem_inhibit (mem_inhibit)
    );

    assign int_n = ~int_req;

    // R13
    idle_ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_start && !win_valid && !mem_inhibit) |=> !mem_inhibit);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (int_n && !mem_inhibit && !dout_oe));

endmodule

// File: tb/test_irq_call_inject.sv
`timescale 1ns/1ps
module test_irq_call_inject;

    localparam logic [7:0] BASE = 8'h40;
    localparam logic [7:0] CLRP = BASE + 8'd16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_req = '0;
    logic       m1_n = 1'b1, iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] addr = '0, din = '0;
    logic       int_n, dout_oe, mem_inhibit;
    logic [7:0] dout;

    always #2.5 clk = ~clk;

    irq_call_inject #(.N_IRQ(8), .BASE_PORT(BASE)) i_irq_call_inject (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din),
        .int_n(int_n), .dout(dout), .dout_oe(dout_oe), .mem_inhibit(mem_inhibit)
    );

    int unsigned n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    logic [15:0] m_vec [8];
    logic [7:0]  m_pend = '0, m_svc = '0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] allowed(input logic [7:0] svc);
        logic [7:0] a;
        for (int i = 0; i < 8; i++) a[i] = ~|(svc & ((8'h2 << i) - 8'h1));
        return a;
    endfunction

    function automatic int winner(input logic [7:0] pend, input logic [7:0] svc);
        logic [7:0] c = pend & allowed(svc);
        for (int i = 0; i < 8; i++) if (c[i]) return i;
        return -1;
    endfunction

    function automatic logic exp_int_n();
        return winner(m_pend, m_svc) < 0;
    endfunction

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk); addr = p; din = d; iorq_n = 0; wr_n = 0;
        @(negedge clk);
        @(negedge clk); iorq_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic set_vec(input int i, input logic [15:0] v);
        io_write(BASE + 8'(2 * i), v[7:0]);
        io_write(BASE + 8'(2 * i + 1), v[15:8]);
        m_vec[i] = v;
    endtask

    task automatic pulse_req(input logic [7:0] mask);
        @(negedge clk); irq_req = mask;
        @(negedge clk);
        @(negedge clk); irq_req = '0;
        @(negedge clk);
        m_pend = m_pend | mask;
    endtask

    task automatic ack_cycle(output logic [7:0] d, output logic oe);
        @(negedge clk); m1_n = 0; iorq_n = 0;
        @(negedge clk); d = dout; oe = dout_oe;
        @(negedge clk); m1_n = 1; iorq_n = 1;
        @(negedge clk);
    endtask

    task automatic mem_read(output logic [7:0] d, output logic oe);
        @(negedge clk); mreq_n = 0; rd_n = 0;
        @(negedge clk); d = dout; oe = dout_oe;
        @(negedge clk); mreq_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic fetch(input logic [7:0] op);
        @(negedge clk); m1_n = 0; mreq_n = 0; rd_n = 0; din = op;
        @(negedge clk);
        @(negedge clk); m1_n = 1; mreq_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic reti();
        int k;
        fetch(8'hED);
        fetch(8'h4D);
        k = -1;
        for (int i = 7; i >= 0; i--) if (m_svc[i]) k = i;
        if (k >= 0) m_svc[k] = 1'b0;
    endtask

    // full injection for the expected winner, checking every byte
    task automatic serve(input string tag);
        logic [7:0] d;
        logic       oe;
        int         w;
        w = winner(m_pend, m_svc);
        ack_cycle(d, oe);
        check({tag, " R4 opcode"}, {8'h0, d}, 16'h00CD);
        check({tag, " R4 oe"}, {15'h0, oe}, 16'h1);
        check({tag, " R6 inhibit on"}, {15'h0, mem_inhibit}, 16'h1);
        mem_read(d, oe);
        check({tag, " R5 low byte"}, {7'h0, oe, d}, {8'h01, m_vec[w][7:0]});
        mem_read(d, oe);
        check({tag, " R5 high byte"}, {7'h0, oe, d}, {8'h01, m_vec[w][15:8]});
        m_pend[w] = 1'b0;
        m_svc[w]  = 1'b1;
        fetch(8'h00);
        check({tag, " R6 inhibit off"}, {15'h0, mem_inhibit}, 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 int_n", {15'h0, int_n}, 16'h1);
        check("R1 inhibit", {15'h0, mem_inhibit}, 16'h0);
        check("R1 oe", {15'h0, dout_oe}, 16'h0);

        // R11: load all handler addresses
        for (int i = 0; i < 8; i++) set_vec(i, 16'($urandom));

        // R13: acknowledge with nothing pending
        ack_cycle(d, oe);
        check("R13 no drive", {15'h0, oe}, 16'h0);
        check("R13 no inhibit", {15'h0, mem_inhibit}, 16'h0);

        // R2: single request
        pulse_req(8'h20);
        check("R2 int_n low", {15'h0, int_n}, 16'h0);

        // R3: lower index wins
        pulse_req(8'h44);
        ack_cycle(d, oe);
        check("R4 opcode", {7'h0, oe, d}, 16'h01CD);
        check("R6 inhibit after ack", {15'h0, mem_inhibit}, 16'h1);
        // R7: higher priority request during the injection
        pulse_req(8'h01);
        mem_read(d, oe);
        check("R3 R7 low byte of line 2", {7'h0, oe, d}, {8'h01, m_vec[2][7:0]});
        mem_read(d, oe);
        check("R3 R7 high byte of line 2", {7'h0, oe, d}, {8'h01, m_vec[2][15:8]});
        // R12: third read is not answered
        mem_read(d, oe);
        check("R12 no drive on extra read", {15'h0, oe}, 16'h0);
        check("R6 inhibit held before fetch", {15'h0, mem_inhibit}, 16'h1);
        m_pend[2] = 1'b0; m_svc[2] = 1'b1;
        fetch(8'h00);
        check("R6 inhibit cleared by fetch", {15'h0, mem_inhibit}, 16'h0);

        // R8: higher priority line 0 may preempt line 2 in service
        check("R8 preempt int_n", {15'h0, int_n}, 16'h0);
        serve("R8 preempt");
        check("R8 lower lines masked", {15'h0, int_n}, 16'h1);

        // R10: interrupted pair does not match
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        fetch(8'h00);
        reti(); // clears line 0
        check("R10 line 2 still masks", {15'h0, int_n}, 16'h1);

        // R9: host clear of line 2
        io_write(CLRP, 8'h04);
        m_svc[2] = 1'b0;
        check("R9 clear reopens int", {15'h0, int_n}, 16'h0);
        serve("R9 follow");
        reti();
        check("R10 reti reopens", {15'h0, int_n}, {15'h0, exp_int_n()});
        serve("R10 follow");
        reti();
        check("R2 all drained", {15'h0, int_n}, {15'h0, exp_int_n()});

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] mask;
            if (($urandom % 4) == 0) begin
                int v = $urandom % 8;
                set_vec(v, 16'($urandom));   // R11
            end
            mask = 8'($urandom);
            if (mask != 0) pulse_req(mask);
            check("R2 R3 random int_n", {15'h0, int_n}, {15'h0, exp_int_n()});
            if (!exp_int_n()) begin
                serve("R5 random");
                reti();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule